// File: doc/BRIEF.md
# Reset and Hardware Power-Down Controller

This block turns two slow, noisy board-level pins into a clean core reset. An active-low reset pin is honoured only after it has been held low long enough. An active-low power-down pin has two meanings. A short low level resets the chip. A long low level puts the chip into a floating power-down state. Requests from a watchdog timeout and from an oscillator fault are merged with the pin requests. The combined request is stretched, and it drives both the core reset and an active-low reset output pin.

While reset is active, the block also samples a power-save/watchdog enable pin. The level seen in the last reset cycle becomes the default watchdog auto-start flag. The live, synchronized level of the same pin decides whether software power-saving modes are allowed. All timing is counted in clock cycles. A machine cycle is `OSC_PER_MC` clocks, which is 12 by default. The block has no data stream, so every pin is a plain level control or status signal.

Top module: `rstpd_ctrl`

## Requirements
- R1: A reset-pin low pulse of at least 24 consecutive clocks (two machine cycles) produces a reset. A shorter pulse, for example 23 clocks, leaves both reset outputs high.
- R2: A power-down-pin low pulse of 12 to 23 clocks produces a reset only, and `pd_float` stays low. A pulse shorter than 12 clocks has no effect.
- R3: A power-down-pin low pulse of L ≥ 24 clocks raises `pd_float` for L−23 cycles, and reset stays asserted for that whole time.
- R4: A one-cycle `wdt_timeout` or `osc_fault` pulse asserts reset from the next clock edge.
- R5: Reset is held for 12 clocks after the last request cycle. A k-cycle internal pulse gives k+12 reset cycles. A reset-pin pulse of L ≥ 24 gives L−11 reset cycles. A power-down pulse of L ≥ 12 gives L+1 reset cycles.
- R6: `rst_out_n` and `core_rst_n` carry the same value in every cycle.
- R7: `wdt_autostart` takes the synchronized enable-pin level of the last reset cycle (1 = watchdog starts). Outside reset it holds, whatever the pin does.
- R8: `psave_allow` is the inverse of the enable pin (pin low = allowed). It follows the pin two clock edges later.
- R9: While `por_n` is low, and just after it is released, `core_rst_n` = 0, `rst_out_n` = 0, `pd_float` = 0 and `wdt_autostart` = 1. Reset is released within 30 clocks once no source is active.
- R10: Leaving power-down runs a stretched reset that samples the enable pin again, so `wdt_autostart` is refreshed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| por_n | input | 1 | Supply power-on reset, asynchronous, active low |
| rst_pin_n | input | 1 | External reset pin, active low |
| hwpd_pin_n | input | 1 | Hardware power-down pin, active low |
| pe_pin | input | 1 | Power-save/watchdog enable pin |
| wdt_timeout | input | 1 | Watchdog timeout request |
| osc_fault | input | 1 | Oscillator watchdog fault request |
| core_rst_n | output | 1 | Core reset, active low |
| rst_out_n | output | 1 | Reset output pin, active low |
| pd_float | output | 1 | Power-down: pins to float |
| wdt_autostart | output | 1 | Watchdog starts after reset |
| psave_allow | output | 1 | Software power-saving modes permitted |

## Verification
A low-time counter that is off by one shows up in two ways. A pulse at the threshold, 24 or 12 clocks, is missed. Otherwise the measured number of reset cycles differs from L−11 or L+1. Either error is visible within one pulse plus one machine cycle. A wrong stretch counter changes the 13-cycle reset that follows a single watchdog pulse. A wrong sampling window for the enable pin shows up in `wdt_autostart` as soon as reset ends. A stuck power-down state shows up as `pd_float` staying high after the pin rises.

// File: rtl/rstpd_pkg.sv
package rstpd_pkg;
  // counter width able to hold the value n
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // index of each external pin in the synchronizer bank
  localparam int PIN_RST  = 0;
  localparam int PIN_HWPD = 1;
  localparam int PIN_PE   = 2;
  localparam int NUM_PINS = 3;
endpackage

// File: rtl/rstpd_sync.sv
module rstpd_sync #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic por_n,
  input  logic d,
  output logic q
);
  logic s1;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      s1 <= RST_VAL;
      q  <= RST_VAL;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/rstpd_lowtimer.sv
module rstpd_lowtimer #(
  parameter int LIMIT = 24,
  parameter int W     = rstpd_pkg::cnt_w(LIMIT)
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         lvl_n,
  output logic [W-1:0] cnt
);
  // consecutive low cycles, saturating at LIMIT, cleared by any high cycle
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                  cnt <= '0;
    else if (lvl_n)              cnt <= '0;
    else if (cnt != W'(LIMIT))   cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/rstpd_stretch.sv
module rstpd_stretch #(
  parameter int HOLD = 12,
  parameter int W    = rstpd_pkg::cnt_w(HOLD)
) (
  input  logic clk,
  input  logic por_n,
  input  logic req,
  output logic act
);
  logic [W-1:0] hold;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      hold <= W'(HOLD);
      act  <= 1'b1;
    end else begin
      act <= req || (hold != '0);
      if (req)               hold <= W'(HOLD);
      else if (hold != '0)   hold <= hold - W'(1);
    end
  end
endmodule

// File: rtl/rstpd_ctrl.sv
module rstpd_ctrl #(
  parameter int OSC_PER_MC  = 12,
  parameter int RST_MC      = 2,
  parameter int HWPD_RST_MC = 1,
  parameter int HWPD_PD_MC  = 2,
  parameter int HOLD_MC     = 1
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_pin_n,
  input  logic hwpd_pin_n,
  input  logic pe_pin,
  input  logic wdt_timeout,
  input  logic osc_fault,
  output logic core_rst_n,
  output logic rst_out_n,
  output logic pd_float,
  output logic wdt_autostart,
  output logic psave_allow
);
  import rstpd_pkg::*;

  localparam int RST_CYC    = OSC_PER_MC * RST_MC;
  localparam int PD_RST_CYC = OSC_PER_MC * HWPD_RST_MC;
  localparam int PD_CYC     = OSC_PER_MC * HWPD_PD_MC;
  localparam int HOLD_CYC   = OSC_PER_MC * HOLD_MC;
  localparam int RW         = cnt_w(RST_CYC);
  localparam int PW         = cnt_w(PD_CYC);

  logic [NUM_PINS-1:0] pin_raw, pin_s;
  assign pin_raw[PIN_RST]  = rst_pin_n;
  assign pin_raw[PIN_HWPD] = hwpd_pin_n;
  assign pin_raw[PIN_PE]   = pe_pin;

  // all pins idle high (pull-ups), so the synchronizers reset to 1
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_sync
    rstpd_sync #(.RST_VAL(1'b1)) u_sync (
      .clk(clk), .por_n(por_n), .d(pin_raw[g]), .q(pin_s[g])
    );
  end

  logic [RW-1:0] rst_cnt;
  logic [PW-1:0] pd_cnt;

  rstpd_lowtimer #(.LIMIT(RST_CYC), .W(RW)) u_rst_tmr (
    .clk(clk), .por_n(por_n), .lvl_n(pin_s[PIN_RST]), .cnt(rst_cnt)
  );
  rstpd_lowtimer #(.LIMIT(PD_CYC), .W(PW)) u_pd_tmr (
    .clk(clk), .por_n(por_n), .lvl_n(pin_s[PIN_HWPD]), .cnt(pd_cnt)
  );

  // power-down state: entered on the PD_CYC-th low sample, left on a high sample
  logic pd_q;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                 pd_q <= 1'b0;
    else if (pin_s[PIN_HWPD])   pd_q <= 1'b0;
    else if (pd_cnt == PW'(PD_CYC - 1)) pd_q <= 1'b1;
  end

  logic pin_rst_req, pd_rst_req, any_req, rst_act;
  assign pin_rst_req = (rst_cnt == RW'(RST_CYC));
  assign pd_rst_req  = (pd_cnt >= PW'(PD_RST_CYC));
  assign any_req     = pin_rst_req | pd_rst_req | pd_q | wdt_timeout | osc_fault;

  rstpd_stretch #(.HOLD(HOLD_CYC)) u_stretch (
    .clk(clk), .por_n(por_n), .req(any_req), .act(rst_act)
  );

  // enable-pin level tracked through reset; frozen once reset ends
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        wdt_autostart <= 1'b1;
    else if (rst_act)  wdt_autostart <= pin_s[PIN_PE];
  end

  assign core_rst_n  = ~rst_act;
  assign rst_out_n   = ~rst_act;
  assign pd_float    = pd_q;
  assign psave_allow = ~pin_s[PIN_PE];
endmodule

// File: rtl/rstpd_ctrl_chk.sv
module rstpd_ctrl_chk (
  input logic clk,
  input logic por_n,
  input logic wdt_timeout,
  input logic osc_fault,
  input logic core_rst_n,
  input logic rst_out_n,
  input logic pd_float,
  input logic wdt_autostart
);
  assert_wdt_reset_R4: assert property (@(posedge clk) disable iff (!por_n)
    wdt_timeout |=> !core_rst_n);

  assert_osc_reset_R4: assert property (@(posedge clk) disable iff (!por_n)
    osc_fault |=> !rst_out_n);

  assert_pd_holds_reset_R3: assert property (@(posedge clk) disable iff (!por_n)
    pd_float |=> !core_rst_n);

  assert_release_quiet_R5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(core_rst_n) |-> (!$past(wdt_timeout) && !$past(osc_fault) && !$past(pd_float)));

  assert_autostart_hold_R7: assert property (@(posedge clk) disable iff (!por_n)
    (core_rst_n && $past(core_rst_n)) |-> $stable(wdt_autostart));
endmodule

bind rstpd_ctrl rstpd_ctrl_chk u_chk (
  .clk(clk), .por_n(por_n), .wdt_timeout(wdt_timeout), .osc_fault(osc_fault),
  .core_rst_n(core_rst_n), .rst_out_n(rst_out_n), .pd_float(pd_float),
  .wdt_autostart(wdt_autostart)
);

// File: tb/tb_rstpd_ctrl.sv
`timescale 1ns/1ps
module tb_rstpd_ctrl;
  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic rst_pin_n = 1'b1, hwpd_pin_n = 1'b1, pe_pin = 1'b1;
  logic wdt_timeout = 1'b0, osc_fault = 1'b0;
  logic core_rst_n, rst_out_n, pd_float, wdt_autostart, psave_allow;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rstpd_ctrl dut (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .hwpd_pin_n(hwpd_pin_n),
    .pe_pin(pe_pin), .wdt_timeout(wdt_timeout), .osc_fault(osc_fault),
    .core_rst_n(core_rst_n), .rst_out_n(rst_out_n), .pd_float(pd_float),
    .wdt_autostart(wdt_autostart), .psave_allow(psave_allow)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // source select: 0 reset pin, 1 power-down pin, 2 watchdog, 3 oscillator fault
  task automatic drive(input int sel, input logic on);
    case (sel)
      0: rst_pin_n   = ~on;
      1: hwpd_pin_n  = ~on;
      2: wdt_timeout = on;
      default: osc_fault = on;
    endcase
  endtask

  task automatic pulse(input int sel, input int len,
                       output int nrst, output int npd, output int nmis);
    nrst = 0; npd = 0; nmis = 0;
    @(negedge clk);
    drive(sel, 1'b1);
    for (int i = 0; i < len + 70; i++) begin
      @(negedge clk);
      if (!core_rst_n) nrst++;
      if (pd_float) npd++;
      if (rst_out_n != core_rst_n) nmis++;
      if (i == len - 1) drive(sel, 1'b0);
    end
  endtask

  // {source, pulse length, expected reset cycles, expected float cycles}
  localparam int NV = 12;
  localparam int VEC[NV][4] = '{
    '{0, 23, 0, 0},    // R1 just below threshold
    '{0, 24, 13, 0},   // R1 at threshold, R5 L-11
    '{0, 30, 19, 0},   // R5
    '{1, 11, 0, 0},    // R2 ignored
    '{1, 12, 13, 0},   // R2 reset only
    '{1, 20, 21, 0},   // R2, R5 L+1
    '{1, 23, 24, 0},   // R2 one short of power-down
    '{1, 24, 25, 1},   // R3 at threshold
    '{1, 30, 31, 7},   // R3
    '{2, 1, 13, 0},    // R4 watchdog
    '{2, 3, 15, 0},    // R5 k+12
    '{3, 1, 13, 0}     // R4 oscillator fault
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int nrst, npd, nmis;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 core_rst_n in por", core_rst_n, 0);
    check("R9 pd_float in por", pd_float, 0);
    por_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 core_rst_n after por", core_rst_n, 0);
    check("R9 rst_out_n after por", rst_out_n, 0);
    check("R9 wdt_autostart after por", wdt_autostart, 1);
    check("R8 psave_allow with pin high", psave_allow, 0);
    repeat (30) @(negedge clk);
    check("R9 reset released", core_rst_n, 1);

    for (int v = 0; v < NV; v++) begin
      pulse(VEC[v][0], VEC[v][1], nrst, npd, nmis);
      check($sformatf("R1/R2/R4/R5 reset cycles vec%0d", v), nrst, VEC[v][2]);
      check($sformatf("R2/R3 float cycles vec%0d", v), npd, VEC[v][3]);
      check($sformatf("R6 output match vec%0d", v), nmis, 0);
      check($sformatf("R5 idle after vec%0d", v), core_rst_n, 1);
    end

    // R7: enable low during reset -> no auto-start; R8 psave follows pin
    @(negedge clk); pe_pin = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 psave_allow with pin low", psave_allow, 1);
    pulse(2, 1, nrst, npd, nmis);
    check("R7 autostart latched low", wdt_autostart, 0);
    @(negedge clk); pe_pin = 1'b1;
    @(negedge clk);
    check("R8 psave latency one edge", psave_allow, 1);
    @(negedge clk);
    check("R8 psave latency two edges", psave_allow, 0);
    repeat (5) @(negedge clk);
    check("R7 autostart holds outside reset", wdt_autostart, 0);

    // R10: leaving power-down resamples the enable pin
    pulse(1, 40, nrst, npd, nmis);
    check("R10 reset cycles after power-down", nrst, 41);
    check("R10 autostart resampled", wdt_autostart, 1);
    check("R10 float cleared", pd_float, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule